// File: doc/BRIEF.md
# Predicated Vector Byte Store Sequencer

This block carries out a single predicated contiguous byte store from a vector register to a byte-wide memory port. A request supplies the vector contents, a predicate with one bit per vector byte, a 64-bit scalar base, a 64-bit scalar index and a 2-bit element-size code. A further flag marks the base as the stack pointer. For each element whose predicate bit is set, the low byte of that element is written to `base + index + e`, one write per cycle. Elements whose predicate bit is clear cost no cycle at all. The index input is only read and is never written back.

When the base is the stack pointer, the block checks that it is 16-byte aligned before any write is issued. If no element is active, a configuration input decides whether that check runs. A failed check suppresses every write of the request. The request then ends with `done` and `fault` raised together. Requests are accepted through a start/busy/done handshake.

Top module: `vec_byte_store`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fault` and `wr_en` are all low.
- R2: Only elements whose predicate bit is set produce a write. Writes come in ascending element order, one per cycle, with no idle cycle between them. The first write appears in the cycle after the start edge.
- R3: The write address for element e is `base + index + e`, wrapping modulo 2^64. The `index` input is used unmodified for every element.
- R4: The element-size code `elem_sz` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The number of elements is VLEN divided by that width. The written byte is the lowest byte of the element, which sits at byte offset e×(width/8) of `vec_data`, with byte 0 at bits 7:0.
- R5: The predicate bit that controls element e is `pred[e×(width/8)]`. All other predicate bits are ignored.
- R6: `done` is a one-cycle pulse in the cycle after the last write. If there are no writes, it comes in the cycle right after the start edge. `busy` is high from the cycle after the start edge up to and including the `done` cycle.
- R7: A `start` seen while `busy` is high is ignored. The running request's writes and result do not change.
- R8: If `base_is_sp` is 1, `base[3:0]` is nonzero and at least one element is active, the request issues no write. It ends with `fault` high in the `done` cycle.
- R9: If no element is active, no write occurs. A misaligned stack-pointer base then raises `fault` only when `sp_chk_empty` is 1.
- R10: When `base_is_sp` is 0, the base alignment never causes a fault. `fault` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| vec_data | input | VLEN | Vector register contents, byte 0 at bits 7:0 |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| base | input | 64 | Scalar base address |
| index | input | 64 | Scalar element index added to the base |
| elem_sz | input | 2 | Element width code (8/16/32/64 bits) |
| base_is_sp | input | 1 | Base comes from the stack pointer |
| sp_chk_empty | input | 1 | Run the alignment check even when no element is active |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Stack-pointer alignment fault, valid with done |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | 64 | Memory byte address |
| wr_data | output | 8 | Memory byte data |

## Verification
Several properties are checked on every cycle. Writes happen only while busy and never in the `done` cycle. `done` lasts a single cycle and is followed by idle. `fault` never appears without `done`. A start taken in idle always raises busy. Two consecutive writes never share an address.

Other behaviour can only be shown by the bench's scenarios. These include the exact addresses and bytes for each element size, the choice of predicate bit, modulo-2^64 wrap of the address, and the count of skipped elements. They also include the fault decision across stack-pointer, alignment and empty-predicate combinations, and the ignoring of a start raised mid-request. Each scenario is compared against a reference model in the bench.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vbs_state_t;

    localparam int ADDR_W       = 64;
    localparam int SP_ALIGN_LSB = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] index;
        logic [1:0]        sz;
        logic              fault;
    } vbs_req_t;

    function automatic logic sp_misaligned(input logic [ADDR_W-1:0] b);
        return |b[SP_ALIGN_LSB-1:0];
    endfunction

endpackage

// File: rtl/vbs_elem_mask.sv
module vbs_elem_mask #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] pred,
    input  logic [1:0]    sz,
    output logic [PW-1:0] active
);
    logic [PW-1:0] cand [4];

    for (genvar s = 0; s < 4; s++) begin : g_size
        for (genvar g = 0; g < PW; g++) begin : g_elem
            localparam int BYTE_POS = g << s;
            if (BYTE_POS < PW) begin : g_in
                assign cand[s][g] = pred[BYTE_POS];
            end else begin : g_out
                assign cand[s][g] = 1'b0;
            end
        end
    end

    assign active = cand[sz];
endmodule

// File: rtl/vbs_pick.sv
module vbs_pick #(
    parameter int PW = 16,
    parameter int IW = 4
) (
    input  logic [PW-1:0] pending,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = PW - 1; i >= 0; i--) begin
            if (pending[i]) idx = IW'(i);
        end
        any = |pending;
    end
endmodule

// File: rtl/vbs_addr_gen.sv
module vbs_addr_gen #(
    parameter int VLEN = 128,
    parameter int IW   = 4
) (
    input  logic [VLEN-1:0] vec,
    input  logic [63:0]     base,
    input  logic [63:0]     index,
    input  logic [1:0]      sz,
    input  logic [IW-1:0]   elem,
    output logic [63:0]     addr,
    output logic [7:0]      data
);
    logic [IW-1:0]   byte_off;
    logic [IW+2:0]   bit_off;

    assign byte_off = elem << sz;
    assign bit_off  = {byte_off, 3'b000};
    assign data     = vec[bit_off +: 8];
    assign addr     = base + index + 64'(elem);
endmodule

// File: rtl/vec_byte_store.sv
module vec_byte_store
    import vbs_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VLEN-1:0]   vec_data,
    input  logic [VLEN/8-1:0] pred,
    input  logic [63:0]       base,
    input  logic [63:0]       index,
    input  logic [1:0]        elem_sz,
    input  logic              base_is_sp,
    input  logic              sp_chk_empty,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              wr_en,
    output logic [63:0]       wr_addr,
    output logic [7:0]        wr_data
);
    localparam int PW = VLEN / 8;
    localparam int IW = $clog2(PW);

    vbs_state_t    state_q;
    vbs_req_t      req_q;
    logic [VLEN-1:0] vec_q;
    logic [PW-1:0] left_q;

    logic [PW-1:0] act_in;
    logic          any_in;
    logic          fault_in;
    logic [IW-1:0] cur;
    logic          any_left;
    logic          running;

    vbs_elem_mask #(.PW(PW)) u_mask (
        .pred   (pred),
        .sz     (elem_sz),
        .active (act_in)
    );

    assign any_in   = |act_in;
    assign fault_in = base_is_sp && sp_misaligned(base) && (any_in || sp_chk_empty);

    vbs_pick #(.PW(PW), .IW(IW)) u_pick (
        .pending (left_q),
        .idx     (cur),
        .any     (any_left)
    );

    vbs_addr_gen #(.VLEN(VLEN), .IW(IW)) u_addr (
        .vec   (vec_q),
        .base  (req_q.base),
        .index (req_q.index),
        .sz    (req_q.sz),
        .elem  (cur),
        .addr  (wr_addr),
        .data  (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            req_q   <= '0;
            vec_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q     <= ST_RUN;
                        vec_q       <= vec_data;
                        req_q.base  <= base;
                        req_q.index <= index;
                        req_q.sz    <= elem_sz;
                        req_q.fault <= fault_in;
                        left_q      <= fault_in ? '0 : act_in;
                    end
                end
                default: begin
                    if (!any_left) state_q <= ST_IDLE;
                    else           left_q[cur] <= 1'b0;
                end
            endcase
        end
    end

    assign running = (state_q == ST_RUN);
    assign busy    = running;
    assign wr_en   = running && any_left;
    assign done    = running && !any_left;
    assign fault   = done && req_q.fault;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic        wr_en,
    input logic [63:0] wr_addr
);
    p_wr_busy_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    p_no_wr_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_fault_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_addr_distinct_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr != $past(wr_addr)));
endmodule

bind vec_byte_store vbs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .fault   (fault),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/vec_byte_store_test.sv
module vec_byte_store_test;
    localparam int VL = 256;
    localparam int PW = VL / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [VL-1:0] r_vec = '0;
    logic [PW-1:0] r_pred = '0;
    logic [63:0]   r_base = '0;
    logic [63:0]   r_idx = '0;
    logic [1:0]    r_sz = '0;
    logic          r_sp = 1'b0;
    logic          r_chk = 1'b0;
    logic busy, done, fault, wr_en;
    logic [63:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] ea [PW];
    logic [7:0]  ed [PW];
    int          en;
    logic        ef;

    always #5 clk = ~clk;

    vec_byte_store #(.VLEN(VL)) uut (
        .clk(clk), .rst(rst), .start(start), .vec_data(r_vec), .pred(r_pred),
        .base(r_base), .index(r_idx), .elem_sz(r_sz), .base_is_sp(r_sp),
        .sp_chk_empty(r_chk), .busy(busy), .done(done), .fault(fault),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // reference model for R2 R3 R4 R5 R8 R9 R10
    task automatic build_expected();
        int nbytes = 1 << r_sz;
        int nel = PW / nbytes;
        logic any = 1'b0;
        en = 0;
        for (int e = 0; e < nel; e++) begin
            int boff = e * nbytes;
            if (r_pred[boff]) begin
                any = 1'b1;
                ea[en] = r_base + r_idx + 64'(e);
                ed[en] = r_vec[boff*8 +: 8];
                en++;
            end
        end
        ef = r_sp && (r_base[3:0] != 4'd0) && (any || r_chk);
        if (ef) en = 0;
    endtask

    task automatic do_req(input bit poke);
        int got = 0;
        bit fin = 0;
        logic [VL-1:0] save_vec;
        build_expected();
        save_vec = r_vec;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < PW + 4 && !fin; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == 1 && poke) begin
                start = 1'b0;
                r_vec = save_vec;
            end
            check("R6 busy", busy === 1'b1, 64'(busy), 64'd1);
            if (wr_en === 1'b1) begin
                if (got < en) begin
                    check("R3 addr", wr_addr === ea[got], wr_addr, ea[got]);
                    check("R4 R5 data", wr_data === ed[got], 64'(wr_data), 64'(ed[got]));
                end else begin
                    check("R2 extra write", 1'b0, 64'(got), 64'(en));
                end
                got++;
            end else if (done === 1'b1) begin
                check("R2 count", got == en, 64'(got), 64'(en));
                check("R8 R9 fault", fault === ef, 64'(fault), 64'(ef));
                fin = 1;
            end else begin
                check("R2 gap", 1'b0, 64'(cyc), 64'(got));
            end
            if (cyc == 0 && poke && en >= 2) begin
                start = 1'b1;
                r_vec = ~save_vec;
            end
        end
        start = 1'b0;
        r_vec = save_vec;
        if (!fin) check("R6 done missing", 1'b0, 64'd0, 64'd1);
        @(negedge clk);
        check("R6 idle after done", busy === 1'b0 && done === 1'b0, 64'(busy), 64'd0);
    endtask

    task automatic rand_vec();
        for (int w = 0; w < VL / 32; w++) r_vec[w*32 +: 32] = $urandom;
    endtask

    task automatic rand_pred();
        logic [PW-1:0] a, b;
        for (int w = 0; w < PW / 32 + 1; w++) begin
            a = (a << 16) ^ PW'($urandom);
            b = (b << 16) ^ PW'($urandom);
        end
        case ($urandom % 4)
            0: r_pred = a;
            1: r_pred = a & b;
            2: r_pred = '1;
            default: r_pred = ($urandom % 3 == 0) ? '0 : (a & b & PW'($urandom));
        endcase
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", busy === 1'b0 && done === 1'b0 && fault === 1'b0 && wr_en === 1'b0,
              {60'd0, busy, done, fault, wr_en}, 64'd0);

        // R4 R5 each size with full predicate
        rand_vec();
        r_base = 64'h1000; r_idx = 64'd5; r_pred = '1; r_sp = 0; r_chk = 0;
        for (int s = 0; s < 4; s++) begin
            r_sz = 2'(s);
            do_req(0);
        end
        // R5 only non-controlling bits set: no writes
        r_sz = 2'd2; r_pred = '0;
        for (int i = 0; i < PW; i++) if (i % 4 != 0) r_pred[i] = 1'b1;
        do_req(0);
        // R3 wrap
        r_sz = 2'd0; r_pred = '1; r_base = 64'hFFFF_FFFF_FFFF_FFF0; r_idx = 64'd8;
        do_req(0);
        // R8 misaligned sp with active element
        r_sp = 1; r_base = 64'h2008; r_idx = 0;
        do_req(0);
        // R8 aligned sp writes normally
        r_base = 64'h2010;
        do_req(0);
        // R9 empty predicate, misaligned sp, check off then on
        r_pred = '0; r_base = 64'h2004; r_chk = 0;
        do_req(0);
        r_chk = 1;
        do_req(0);
        // R10 misaligned non-sp base
        r_sp = 0; r_pred = '1; r_base = 64'h3003;
        do_req(0);
        // R7 start while busy
        r_pred = '1; r_base = 64'h4000; rand_vec();
        do_req(1);

        for (int n = 0; n < 300; n++) begin
            rand_vec();
            rand_pred();
            r_sz  = 2'($urandom % 4);
            r_sp  = ($urandom % 3 == 0);
            r_chk = $urandom % 2;
            r_base = {$urandom, $urandom};
            if ($urandom % 2 == 0) r_base[3:0] = 4'd0;
            r_idx = ($urandom % 4 == 0) ? (64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom % 8))
                                        : {$urandom, $urandom};
            do_req($urandom % 5 == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule